// File: doc/BRIEF.md
# Clock-Cycle Time Error Adjuster

This block trims the length of individual seconds in a real-time clock so that a crystal running slightly fast or slow still keeps correct time. The seconds prescaler, which sits outside the block, counts 32 kHz clock enables and reports each wrap. The block counts these seconds over a window of either 10 or 60 seconds. For the one second that closes each window, it supplies the prescaler with a terminal count that is longer or shorter than nominal by a programmed number of cycles. Every other second gets the nominal terminal count.

Software programs the block through two byte registers. The trim register holds the cycle count and the direction of the correction. The control register holds the auto-adjust enable and the window select. A written byte is not applied at once. It is held and takes effect only after a fixed number of 32 kHz enables, and a read returns the applied value, so software polls until it reads back what it wrote. The window select can only change while the applied direction is zero. A calendar reset, a change of window select, or a disabled enable restarts the window count.

Top module: `cyc_trim_adj`

## Requirements
- R1: After reset, both registers read 0x00, the window count is at its start, and `sec_limit` equals NOMINAL_CYC-1 (32767 by default).
- R2: Trim register (address 0): bits 5:0 are the cycle magnitude and bits 7:6 are the direction. A written byte reads back only after SYNC_TICKS (3 by default) 32 kHz enables have passed; until then the previous value reads back.
- R3: Control register (address 1): bit 0 selects the window (1 = 10 seconds, 0 = 60 seconds), bit 1 is the auto-adjust enable, and bits 7:2 read as zero.
- R4: With auto-adjust on, each qualified wrap (`presc_wrap` and `tick32` both high) advances the window count. The second that closes the window is the 60th in a 60-second window or the 10th in a 10-second window, and only that second is adjusted; the count then starts again.
- R5: Direction 1 (add) makes the closing second's `sec_limit` NOMINAL_CYC-1+magnitude.
- R6: Direction 2 (subtract) makes the closing second's `sec_limit` NOMINAL_CYC-1-magnitude.
- R7: Direction 0 and direction 3 leave `sec_limit` at nominal in every second, whatever the magnitude.
- R8: With window select 1, the 10th second of each window is adjusted.
- R9: With auto-adjust off, `sec_limit` stays nominal and the window count is held at its start.
- R10: An applied control write whose window select differs from the current one keeps the old select when the applied trim direction is nonzero. Its enable bit is still taken.
- R11: A calendar reset or an applied change of window select restarts the window count. This holds even when a wrap arrives in the same cycle.
- R12: Pending register writes and window counting advance only on cycles where `tick32` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick32 | input | 1 | 32 kHz clock enable |
| presc_wrap | input | 1 | Prescaler reached its terminal count (qualified by tick32) |
| cal_reset | input | 1 | Calendar reset; restarts the window count |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register address, used for both read and write |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Applied value of the addressed register |
| sec_limit | output | 16 | Terminal count for the current second |

## Verification
Two events can land in the same cycle: a restart of the window count and a qualified wrap. The bench provokes this by raising `cal_reset` together with a wrap partway through a window. It separately provokes it by applying a window-select change partway through a window. In both cases it judges the outcome by counting wraps to the next adjusted `sec_limit`; a count that was not restarted would place the adjusted second elsewhere. A trim write and a control write can also take effect in the same cycle. The ordering rule is judged by reading back the control register while a nonzero direction is applied.

// File: rtl/cta_pkg.sv
package cta_pkg;

  localparam int unsigned MAG_W  = 6;
  localparam int unsigned TRIM_W = MAG_W + 2;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_ADD  = 2'd1,
    DIR_SUB  = 2'd2,
    DIR_RSVD = 2'd3
  } dir_e;

  typedef struct packed {
    dir_e             dir;
    logic [MAG_W-1:0] mag;
  } trim_t;

  // Terminal count of a second; the adjustment applies only when active.
  function automatic int unsigned adj_limit(int unsigned nominal, dir_e dir,
                                            int unsigned mag, logic active);
    int unsigned base;
    base = nominal - 1;
    if (!active) return base;
    case (dir)
      DIR_ADD: return base + mag;
      DIR_SUB: return base - mag;
      default: return base;
    endcase
  endfunction

  // Index of the last second in the selected window.
  function automatic int unsigned window_last(logic short_sel, int unsigned short_s,
                                              int unsigned long_s);
    return short_sel ? (short_s - 1) : (long_s - 1);
  endfunction

endpackage

// File: rtl/cta_wr_sync.sv
module cta_wr_sync #(
  parameter int unsigned DW  = 8,
  parameter int unsigned DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] ldata,
  output logic          fire,
  output logic [DW-1:0] fdata
);
  localparam int unsigned CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= '0;
    end else if (load) begin
      cnt  <= CW'(DLY);
      hold <= ldata;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign fire  = tick && !load && (cnt == CW'(1));
  assign fdata = hold;

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R2

  AST_WAIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt)); // R12

endmodule

// File: rtl/cta_window_cnt.sv
module cta_window_cnt
  import cta_pkg::*;
#(
  parameter int unsigned SHORT_SECS = 10,
  parameter int unsigned LONG_SECS  = 60,
  parameter int unsigned CNT_W      = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic restart,
  input  logic short_sel,
  output logic last_sec
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = CNT_W'(window_last(short_sel, SHORT_SECS, LONG_SECS));
  assign last_sec = (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (step) begin
      if (last_sec)      cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx); // R4

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !last_sec) |=> cnt == $past(cnt) + 1'b1); // R4

  AST_CNT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && last_sec) |=> cnt == '0); // R4

  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0); // R11

endmodule

// File: rtl/cta_limit.sv
module cta_limit
  import cta_pkg::*;
#(
  parameter int unsigned NOMINAL_CYC = 32768,
  parameter int unsigned LIM_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  trim_t            trim,
  input  logic             active,
  output logic [LIM_W-1:0] limit
);
  localparam int unsigned MAG_MAX = (1 << MAG_W) - 1;

  assign limit = LIM_W'(adj_limit(NOMINAL_CYC, trim.dir, int'(trim.mag), active));

  AST_NOMINAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> limit == LIM_W'(NOMINAL_CYC - 1)); // R9

  AST_NOMINAL_NODIR: assert property (@(posedge clk) disable iff (!rst_n)
    (trim.dir == DIR_NONE || trim.dir == DIR_RSVD) |-> limit == LIM_W'(NOMINAL_CYC - 1)); // R7

  AST_LIMIT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (limit >= LIM_W'(NOMINAL_CYC - 1 - MAG_MAX)) && (limit <= LIM_W'(NOMINAL_CYC - 1 + MAG_MAX))); // R5

endmodule

// File: rtl/cyc_trim_adj.sv
module cyc_trim_adj
  import cta_pkg::*;
#(
  parameter int unsigned NOMINAL_CYC = 32768,
  parameter int unsigned SHORT_SECS  = 10,
  parameter int unsigned LONG_SECS   = 60,
  parameter int unsigned SYNC_TICKS  = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick32,
  input  logic              presc_wrap,
  input  logic              cal_reset,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [15:0]       sec_limit
);
  localparam int unsigned NUM_REGS  = 2;
  localparam int unsigned REG_TRIM  = 0;
  localparam int unsigned REG_CTRL  = 1;
  localparam int unsigned MAX_SECS  = (LONG_SECS > SHORT_SECS) ? LONG_SECS : SHORT_SECS;
  localparam int unsigned CNT_W     = $clog2(MAX_SECS);
  localparam int unsigned LIM_W     = 16;

  // Register write path: one delayed-apply stage per register.
  logic [NUM_REGS-1:0]             sync_fire;
  logic [NUM_REGS-1:0][DATA_W-1:0] sync_data;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wsync
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(g));
    cta_wr_sync #(.DW(DATA_W), .DLY(SYNC_TICKS)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick32),
      .load  (hit),
      .ldata (wdata),
      .fire  (sync_fire[g]),
      .fdata (sync_data[g])
    );
  end

  // Applied register state.
  trim_t trim_q;
  logic  auto_en_q;
  logic  short_sel_q;

  logic  trim_apply;
  logic  ctrl_apply;
  logic  dir_busy;
  logic  sel_request;
  logic  sel_change;

  assign trim_apply  = sync_fire[REG_TRIM];
  assign ctrl_apply  = sync_fire[REG_CTRL];
  assign dir_busy    = (trim_q.dir != DIR_NONE);
  assign sel_request = sync_data[REG_CTRL][0];
  assign sel_change  = ctrl_apply && !dir_busy && (sel_request != short_sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= '{dir: DIR_NONE, mag: '0};
    end else if (trim_apply) begin
      trim_q <= trim_t'(sync_data[REG_TRIM][TRIM_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_en_q   <= 1'b0;
      short_sel_q <= 1'b0;
    end else if (ctrl_apply) begin
      auto_en_q <= sync_data[REG_CTRL][1];
      if (!dir_busy) short_sel_q <= sel_request;
    end
  end

  // Readback of applied values.
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(REG_TRIM)) rdata[TRIM_W-1:0] = trim_q;
    else                           rdata[1:0]        = {auto_en_q, short_sel_q};
  end

  // Window counting.
  logic sec_step;
  logic win_restart;
  logic win_last;
  logic adj_active;

  assign sec_step    = tick32 && presc_wrap && auto_en_q;
  assign win_restart = cal_reset || sel_change || !auto_en_q;

  cta_window_cnt #(
    .SHORT_SECS (SHORT_SECS),
    .LONG_SECS  (LONG_SECS),
    .CNT_W      (CNT_W)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (sec_step),
    .restart   (win_restart),
    .short_sel (short_sel_q),
    .last_sec  (win_last)
  );

  assign adj_active = auto_en_q && win_last;

  cta_limit #(
    .NOMINAL_CYC (NOMINAL_CYC),
    .LIM_W       (LIM_W)
  ) u_limit (
    .clk    (clk),
    .rst_n  (rst_n),
    .trim   (trim_q),
    .active (adj_active),
    .limit  (sec_limit)
  );

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    dir_busy |=> short_sel_q == $past(short_sel_q)); // R10

  AST_TRIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !trim_apply |=> $stable(trim_q)); // R2

  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_apply |=> $stable(auto_en_q) && $stable(short_sel_q)); // R3

endmodule

// File: tb/sim_cyc_trim_adj.sv
`timescale 1ns/1ps
module sim_cyc_trim_adj;
  localparam int NOM  = 32768;
  localparam int BASE = NOM - 1;
  localparam int DLY  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick32 = 1'b1;
  logic       presc_wrap = 1'b0;
  logic       cal_reset = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [15:0] sec_limit;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cyc_trim_adj u0 (
    .clk(clk), .rst_n(rst_n), .tick32(tick32), .presc_wrap(presc_wrap),
    .cal_reset(cal_reset), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sec_limit(sec_limit)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d, input bit settle);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    if (settle) repeat (DLY) @(negedge clk);
  endtask

  task automatic rd_check(input string tag, input logic a, input int exp);
    addr = a; #1;
    check(tag, int'(rdata), exp);
  endtask

  task automatic pulse_wrap(input int n, input bit with_reset);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); presc_wrap = 1'b1; cal_reset = with_reset;
      @(negedge clk); presc_wrap = 1'b0; cal_reset = 1'b0;
    end
  endtask

  task automatic lim_check(input string tag, input int exp);
    #1; check(tag, int'(sec_limit), exp);
  endtask

  task automatic t_reset;
    rd_check("R1 trim reset", 1'b0, 0);
    rd_check("R1 ctrl reset", 1'b1, 0);
    lim_check("R1 limit reset", BASE);
  endtask

  task automatic t_regs;
    wr_reg(1'b0, 8'h45, 1'b0);
    rd_check("R2 trim before delay", 1'b0, 8'h00);
    repeat (DLY) @(negedge clk);
    rd_check("R2 trim after delay", 1'b0, 8'h45);
    wr_reg(1'b1, 8'hFE, 1'b1);
    rd_check("R3 ctrl upper bits zero", 1'b1, 8'h02);
    wr_reg(1'b0, 8'h00, 1'b1);
    wr_reg(1'b1, 8'hFF, 1'b1);
    rd_check("R3 ctrl short select", 1'b1, 8'h03);
    wr_reg(1'b1, 8'h02, 1'b1);
    rd_check("R3 ctrl long select", 1'b1, 8'h02);
  endtask

  task automatic t_long_add;
    wr_reg(1'b0, 8'h45, 1'b1);
    pulse_wrap(58, 1'b0);
    lim_check("R4 second 59 nominal", BASE);
    pulse_wrap(1, 1'b0);
    lim_check("R5 closing second add", BASE + 5);
    pulse_wrap(1, 1'b0);
    lim_check("R4 next window nominal", BASE);
    pulse_wrap(59, 1'b0);
    lim_check("R4 second window add", BASE + 5);
    pulse_wrap(1, 1'b0);
  endtask

  task automatic t_sub;
    wr_reg(1'b0, 8'h87, 1'b1);
    pulse_wrap(59, 1'b0);
    lim_check("R6 closing second sub", BASE - 7);
    pulse_wrap(1, 1'b0);
  endtask

  task automatic t_no_dir;
    wr_reg(1'b0, 8'hC9, 1'b1);
    pulse_wrap(59, 1'b0);
    lim_check("R7 direction 3 nominal", BASE);
    pulse_wrap(1, 1'b0);
    wr_reg(1'b0, 8'h09, 1'b1);
    pulse_wrap(59, 1'b0);
    lim_check("R7 direction 0 nominal", BASE);
    pulse_wrap(1, 1'b0);
    rd_check("R7 trim readback", 1'b0, 8'h09);
  endtask

  task automatic t_sel_hold;
    wr_reg(1'b0, 8'h45, 1'b1);
    wr_reg(1'b1, 8'h03, 1'b1);
    rd_check("R10 select kept", 1'b1, 8'h02);
    wr_reg(1'b1, 8'h01, 1'b1);
    rd_check("R10 enable taken", 1'b1, 8'h00);
  endtask

  task automatic t_disable;
    pulse_wrap(59, 1'b0);
    lim_check("R9 disabled nominal", BASE);
    pulse_wrap(60, 1'b0);
    lim_check("R9 disabled still nominal", BASE);
    wr_reg(1'b1, 8'h02, 1'b1);
    pulse_wrap(59, 1'b0);
    lim_check("R9 count held at start", BASE + 5);
    pulse_wrap(1, 1'b0);
  endtask

  task automatic t_short;
    wr_reg(1'b0, 8'h00, 1'b1);
    wr_reg(1'b1, 8'h03, 1'b1);
    wr_reg(1'b0, 8'h83, 1'b1);
    pulse_wrap(8, 1'b0);
    lim_check("R8 ninth second nominal", BASE);
    pulse_wrap(1, 1'b0);
    lim_check("R8 tenth second sub", BASE - 3);
    pulse_wrap(1, 1'b0);
    lim_check("R8 after window nominal", BASE);
  endtask

  task automatic t_restart;
    pulse_wrap(5, 1'b0);
    pulse_wrap(1, 1'b1);
    pulse_wrap(8, 1'b0);
    lim_check("R11 reset with wrap, 8 later", BASE);
    pulse_wrap(1, 1'b0);
    lim_check("R11 reset with wrap, 9 later", BASE - 3);
    pulse_wrap(1, 1'b0);
    wr_reg(1'b0, 8'h00, 1'b1);
    wr_reg(1'b1, 8'h02, 1'b1);
    pulse_wrap(5, 1'b0);
    wr_reg(1'b1, 8'h03, 1'b1);
    wr_reg(1'b0, 8'h83, 1'b1);
    pulse_wrap(8, 1'b0);
    lim_check("R11 select change, 8 later", BASE);
    pulse_wrap(1, 1'b0);
    lim_check("R11 select change, 9 later", BASE - 3);
    pulse_wrap(1, 1'b0);
  endtask

  task automatic t_tick_gate;
    tick32 = 1'b0;
    wr_reg(1'b0, 8'h4A, 1'b0);
    repeat (10) @(negedge clk);
    rd_check("R12 no apply without tick", 1'b0, 8'h83);
    pulse_wrap(20, 1'b0);
    tick32 = 1'b1;
    repeat (DLY) @(negedge clk);
    rd_check("R12 apply after ticks", 1'b0, 8'h4A);
    pulse_wrap(9, 1'b0);
    lim_check("R12 gated wraps not counted", BASE + 10);
    pulse_wrap(1, 1'b0);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_long_add();
    t_sub();
    t_no_dir();
    t_sel_hold();
    t_disable();
    t_short();
    t_restart();
    t_tick_gate();
    finish_up();
  end

endmodule